// File: doc/BRIEF.md
# Axis Sample-Ready and Overrun Status Tracker

This block keeps the new-sample and overrun flags for a multi-axis sensor front end whose 16-bit axis samples are read out over a byte bus, high byte first. The acquisition logic pulses one strobe per axis when that axis finishes a conversion. It pulses a separate strobe when a complete set of all axes has been captured. The bus logic pulses one read strobe per axis whenever that axis's high-byte data register is fetched.

The block folds these events into a registered status byte. The byte holds a ready flag and an overrun flag for each axis, plus a ready flag and an overrun flag for the whole set. A per-axis flag is cleared by a single high-byte read of that axis. The set flags stay up until every axis high byte has been read since the last complete set. A registered one-cycle event pulse follows each completed set, for use by interrupt logic.

The status view is meant for operation with the sample queue bypassed; in queued operation another status source applies.

Top module: `axis_ready_tracker`

## Requirements
- R1: Synchronous active-high reset clears all status bits and the event pulse. Both are zero in the cycle after reset is sampled.
- R2: Status layout with the default of three axes: bit 0 X ready, bit 1 Y ready, bit 2 Z ready, bit 3 set ready, bit 4 X overrun, bit 5 Y overrun, bit 6 Z overrun, bit 7 set overrun.
- R3: An axis acquisition strobe makes that axis's ready bit 1 on the next clock.
- R4: A high-byte read of an axis, without an acquisition strobe for that axis in the same cycle, clears both that axis's ready bit and its overrun bit on the next clock.
- R5: An axis acquisition strobe while that axis's ready bit is 1 sets its overrun bit on the next clock.
- R6: When an axis acquisition strobe and a read of that axis share a cycle, the acquisition wins. Ready stays or becomes 1, and overrun is set if ready was already 1.
- R7: A full-set strobe makes set-ready 1. Set-ready clears only after each axis high byte has been read at least once since that strobe, in any order and in any cycles. Repeated reads of one axis do not clear it.
- R8: A full-set strobe while set-ready is 1 sets set-overrun. Set-overrun clears together with set-ready.
- R9: A full-set strobe in the same cycle as the last outstanding high-byte read keeps set-ready at 1 and restarts the read tracking for the new set.
- R10: The event pulse is 1 for exactly the cycle after each full-set strobe and 0 otherwise.
- R11: High-byte reads while no flags are set leave the status at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acq_done | input | N_AXES | Per-axis acquisition-complete strobe |
| set_done | input | 1 | Full axis set captured strobe |
| hi_rd | input | N_AXES | Per-axis high-byte read strobe |
| status | output | 2*N_AXES+2 | Registered ready and overrun flags |
| drdy_pulse | output | 1 | One-cycle event after each full set |

## Verification
On every cycle the assertions check the per-axis set, clear and overrun rules, that an overrun flag never stands without its ready flag, the timing of the event pulse, and that set-ready cannot drop in a cycle without a read. Only the bench's scenarios can show that set-ready waits for all axes and not just one. The same holds for read order across cycles, for the coincident strobe-and-final-read case restarting the tracking, and for the exact byte values at each step.

// File: rtl/axis_ready_pkg.sv
package axis_ready_pkg;

  // Width of the packed status vector for a given axis count.
  function automatic int status_width(input int n_axes);
    return 2 * n_axes + 2;
  endfunction

  // Bit index of the whole-set ready flag.
  function automatic int set_rdy_bit(input int n_axes);
    return n_axes;
  endfunction

  // Bit index of an axis overrun flag.
  function automatic int axis_ovr_bit(input int n_axes, input int axis);
    return n_axes + 1 + axis;
  endfunction

  // Bit index of the whole-set overrun flag.
  function automatic int set_ovr_bit(input int n_axes);
    return 2 * n_axes + 1;
  endfunction

endpackage

// File: rtl/axis_flag_cell.sv
// Ready/overrun pair for one axis. Acquisition has priority over the read clear.
module axis_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic acq,
  input  logic rd,
  output logic rdy,
  output logic ovr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
    end else if (acq) begin
      rdy <= 1'b1;
      if (rdy) ovr <= 1'b1;
    end else if (rd) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
    end
  end

endmodule

// File: rtl/axis_set_tracker.sv
// Whole-set ready/overrun flags with a mask of axes still awaiting a high-byte read.
module axis_set_tracker #(
  parameter int N_AXES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_done,
  input  logic [N_AXES-1:0] hi_rd,
  output logic              set_rdy,
  output logic              set_ovr,
  output logic              evt
);

  localparam logic [N_AXES-1:0] ALL_PENDING = {N_AXES{1'b1}};

  logic [N_AXES-1:0] pend_q;
  logic [N_AXES-1:0] pend_after_rd;

  assign pend_after_rd = pend_q & ~hi_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      set_rdy <= 1'b0;
      set_ovr <= 1'b0;
    end else if (set_done) begin
      pend_q  <= ALL_PENDING;
      set_rdy <= 1'b1;
      if (set_rdy) set_ovr <= 1'b1;
    end else if (set_rdy) begin
      pend_q <= pend_after_rd;
      if (pend_after_rd == '0) begin
        set_rdy <= 1'b0;
        set_ovr <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) evt <= 1'b0;
    else     evt <= set_done;
  end

endmodule

// File: rtl/axis_ready_tracker.sv
module axis_ready_tracker
  import axis_ready_pkg::*;
#(
  parameter int N_AXES = 3,
  localparam int SW = 2 * N_AXES + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_AXES-1:0] acq_done,
  input  logic              set_done,
  input  logic [N_AXES-1:0] hi_rd,
  output logic [SW-1:0]     status,
  output logic              drdy_pulse
);

  logic [N_AXES-1:0] ax_rdy;
  logic [N_AXES-1:0] ax_ovr;
  logic              set_rdy;
  logic              set_ovr;

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    axis_flag_cell u_cell (
      .clk (clk),
      .rst (rst),
      .acq (acq_done[g]),
      .rd  (hi_rd[g]),
      .rdy (ax_rdy[g]),
      .ovr (ax_ovr[g])
    );
  end

  axis_set_tracker #(.N_AXES(N_AXES)) u_set (
    .clk      (clk),
    .rst      (rst),
    .set_done (set_done),
    .hi_rd    (hi_rd),
    .set_rdy  (set_rdy),
    .set_ovr  (set_ovr),
    .evt      (drdy_pulse)
  );

  // Packing order is fixed: axis ready, set ready, axis overrun, set overrun.
  assign status = {set_ovr, ax_ovr, set_rdy, ax_rdy};

endmodule

// File: rtl/axis_ready_tracker_chk.sv
module axis_ready_tracker_chk #(
  parameter int N_AXES = 3,
  localparam int SW = 2 * N_AXES + 2
) (
  input logic              clk,
  input logic              rst,
  input logic [N_AXES-1:0] acq_done,
  input logic              set_done,
  input logic [N_AXES-1:0] hi_rd,
  input logic [SW-1:0]     status,
  input logic              drdy_pulse
);

  // R1: reset empties every flag
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (status == '0 && !drdy_pulse));

  for (genvar i = 0; i < N_AXES; i++) begin : g_ax
    // R3: acquisition raises ready
    a_r3_acq_sets_ready: assert property (@(posedge clk) disable iff (rst)
      acq_done[i] |=> status[i]);
    // R5: acquisition on a ready axis raises overrun
    a_r5_overrun: assert property (@(posedge clk) disable iff (rst)
      (acq_done[i] && status[i]) |=> status[N_AXES+1+i]);
    // R4: read clears ready and overrun
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
      (hi_rd[i] && !acq_done[i]) |=> (!status[i] && !status[N_AXES+1+i]));
    // R4: an overrun flag never stands without its ready flag
    a_r4_ovr_needs_rdy: assert property (@(posedge clk) disable iff (rst)
      status[N_AXES+1+i] |-> status[i]);
  end

  // R7: set-ready cannot fall in a cycle with no read
  a_r7_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    (status[N_AXES] && hi_rd == '0) |=> status[N_AXES]);
  // R8: set strobe over a pending set raises set overrun
  a_r8_set_overrun: assert property (@(posedge clk) disable iff (rst)
    (set_done && status[N_AXES]) |=> status[2*N_AXES+1]);
  // R9: set strobe always leaves set-ready high
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_done |=> status[N_AXES]);
  // R10: event pulse follows the set strobe exactly
  a_r10_pulse_on: assert property (@(posedge clk) disable iff (rst)
    set_done |=> drdy_pulse);
  a_r10_pulse_off: assert property (@(posedge clk) disable iff (rst)
    !set_done |=> !drdy_pulse);

endmodule

bind axis_ready_tracker axis_ready_tracker_chk #(.N_AXES(N_AXES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acq_done   (acq_done),
  .set_done   (set_done),
  .hi_rd      (hi_rd),
  .status     (status),
  .drdy_pulse (drdy_pulse)
);

// File: tb/axis_ready_tracker_test.sv
module axis_ready_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] acq_done = '0;
  logic       set_done = 1'b0;
  logic [2:0] hi_rd = '0;
  logic [7:0] status;
  logic       drdy_pulse;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axis_ready_tracker uut (
    .clk(clk), .rst(rst), .acq_done(acq_done), .set_done(set_done),
    .hi_rd(hi_rd), .status(status), .drdy_pulse(drdy_pulse)
  );

  // {acq[2:0], set, rd[2:0], expected status[7:0], expected pulse}
  // Status bits per R2: 0 X rdy, 1 Y rdy, 2 Z rdy, 3 set rdy, 4..6 axis ovr, 7 set ovr.
  localparam logic [15:0] VEC [NV] = '{
    {3'b001, 1'b0, 3'b000, 8'h01, 1'b0},  // R3 X ready
    {3'b001, 1'b0, 3'b000, 8'h11, 1'b0},  // R5 X overrun
    {3'b000, 1'b0, 3'b001, 8'h00, 1'b0},  // R4 X read clears both
    {3'b111, 1'b1, 3'b000, 8'h0F, 1'b1},  // R7 R10 full set
    {3'b000, 1'b0, 3'b000, 8'h0F, 1'b0},  // R10 pulse single cycle
    {3'b000, 1'b0, 3'b001, 8'h0E, 1'b0},  // R7 X read, set still pending
    {3'b000, 1'b0, 3'b001, 8'h0E, 1'b0},  // R7 repeated X read
    {3'b000, 1'b0, 3'b100, 8'h0A, 1'b0},  // R7 Z read
    {3'b000, 1'b0, 3'b010, 8'h00, 1'b0},  // R7 last read clears set ready
    {3'b111, 1'b1, 3'b000, 8'h0F, 1'b1},  // R2 R3 layout of full set
    {3'b111, 1'b1, 3'b000, 8'hFF, 1'b1},  // R5 R8 all overrun
    {3'b000, 1'b0, 3'b111, 8'h00, 1'b0},  // R4 R8 clear everything
    {3'b010, 1'b0, 3'b010, 8'h02, 1'b0},  // R6 acq beats read
    {3'b010, 1'b0, 3'b010, 8'h22, 1'b0},  // R6 acq beats read, overrun
    {3'b000, 1'b0, 3'b010, 8'h00, 1'b0},  // R4 Y read
    {3'b000, 1'b0, 3'b111, 8'h00, 1'b0},  // R11 reads with nothing ready
    {3'b111, 1'b1, 3'b000, 8'h0F, 1'b1},  // R7 new set
    {3'b000, 1'b0, 3'b011, 8'h0C, 1'b0},  // R7 X,Y read
    {3'b111, 1'b1, 3'b100, 8'hCF, 1'b1},  // R9 set with final read
    {3'b000, 1'b0, 3'b111, 8'h00, 1'b0}   // R9 tracking restarted, all reads clear
  };

  task automatic check(input string req, input logic [7:0] exp_s, input logic exp_p);
    checks++;
    if (status !== exp_s || drdy_pulse !== exp_p) begin
      errors++;
      $display("FAIL %s: status=%h pulse=%b expected status=%h pulse=%b",
               req, status, drdy_pulse, exp_s, exp_p);
    end
  endtask

  task automatic step(input logic [2:0] a, input logic s, input logic [2:0] r);
    @(negedge clk);
    acq_done = a; set_done = s; hi_rd = r;
    @(posedge clk);
    #1;
    acq_done = '0; set_done = 1'b0; hi_rd = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", 8'h00, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][15:13], VEC[v][12], VEC[v][11:9]);
      check($sformatf("vector %0d", v), VEC[v][8:1], VEC[v][0]);
    end

    // R1: reset in mid-state with a pulse pending
    step(3'b111, 1'b1, 3'b000);
    check("R2 R10 before reset", 8'h0F, 1'b1);
    step(3'b111, 1'b1, 3'b000);
    check("R8 before reset", 8'hFF, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset mid-state", 8'h00, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R11: lone Z read after reset leaves zero
    step(3'b000, 1'b0, 3'b100);
    check("R11 read after reset", 8'h00, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule